// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 memory from power-on to an operational state before the normal memory controller takes over the command bus. After reset it holds clock enable low for a long stabilisation interval. It then raises clock enable and waits a short settling gap. It then issues a fixed series of commands: precharge-all, the extended mode register load, a mode register load that resets the DLL, a DLL settle wait, a second precharge-all, two auto-refreshes, and a final mode register load that releases the DLL reset. After a last lock wait it raises `done_o`.

The spacing between commands comes from parameters given in clock cycles: precharge period, refresh cycle time, mode-register-set spacing, DLL wait and power-up wait. Every cycle that does not carry a command drives NOP. The extended mode and mode register contents come from input ports, so software or straps choose additive latency, CAS latency, burst length and the other settings. The sequencer owns only the DLL-reset bit of the mode register.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst_n` is low, and for `PWR_WAIT` cycles after it is released, `cke_o` is 0, `cmd_o` is NOP (3'b111), `ba_o` and `addr_o` are 0 and `done_o` is 0.
- R2: `cke_o` rises exactly `PWR_WAIT` cycles after reset release and stays high until the next reset.
- R3: The first precharge-all (`cmd_o` = 3'b010, `addr_o` bit 10 set, `ba_o` = 0) comes `CKE_GAP` cycles after `cke_o` rises. No command is issued while `cke_o` is low.
- R4: `TRP` cycles after the first precharge-all, a mode register load (`cmd_o` = 3'b000) with `ba_o` = 1 drives `emr_val_i` on `addr_o`.
- R5: `TMRD` cycles later, a mode register load with `ba_o` = 0 drives `mr_val_i` with bit 8 (DLL reset) forced to 1.
- R6: `DLL_WAIT` cycles after the DLL-reset load, a second precharge-all is issued.
- R7: Two refreshes (`cmd_o` = 3'b001, `ba_o` = 0, `addr_o` = 0) follow. The first comes `TRP` cycles after the second precharge-all, and the second comes `TRFC` cycles after the first.
- R8: `TRFC` cycles after the second refresh, a mode register load with `ba_o` = 0 drives `mr_val_i` with bit 8 forced to 0 and all other bits unchanged.
- R9: `done_o` rises `DLL_WAIT` cycles after the final load and then stays high. Every cycle other than the seven commands above is NOP, including every cycle after `done_o` rises.
- R10: A reset in any cycle, including the cycle in which `done_o` would rise, returns the block to the R1 state. The whole sequence then restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| emr_val_i | input | ADDR_W | Extended mode register contents |
| mr_val_i | input | ADDR_W | Mode register contents (DLL reset bit overridden) |
| cke_o | output | 1 | Clock enable to memory |
| cmd_o | output | 3 | {RAS#, CAS#, WE#} command code |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| done_o | output | 1 | Sequence complete; command bus may be handed over |

## Verification
Two events can meet in one cycle: the expiry of the final lock wait and a reset. The bench provokes this by lowering `rst_n` so that the reset edge is the same edge on which `done_o` would rise. It judges the result by seeing `done_o` and `cke_o` both low in that cycle, and then a full, correctly spaced sequence after release. A second collision places a reset in the middle of the command phase. The outputs must go straight back to the power-wait state, and no half-finished command spacing may carry over into the rerun.

// File: rtl/ddr2_init_pkg.sv
// Shared types for the DDR2 initialization sequencer.
// Assumes commands are coded as {RAS#, CAS#, WE#} with chip select held active.
package ddr2_init_pkg;
    typedef enum logic [2:0] {
        CMD_LMR = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_NOP = 3'b111
    } cmd_e;

    // Ordered phases; the sequencer steps through them in this order.
    typedef enum logic [3:0] {
        PH_PWR, PH_CKE, PH_PALL1, PH_EMR, PH_MRDLL,
        PH_PALL2, PH_REF1, PH_REF2, PH_MRRUN, PH_DONE
    } phase_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/ddr2_init_timer.sv
// Phase timer: counts cycles inside the current phase and flags its first and last cycle.
// Assumes len_i is at least 1 and only changes on the cycle after last_o.
module ddr2_init_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] len_i,
    output logic             first_o,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt;

    // Count up within a phase and wrap to zero on its last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || last_o) cnt <= '0;
        else                  cnt <= cnt + CNT_W'(1);
    end

    // Decode phase boundaries from the count.
    always_comb begin
        first_o = (cnt == '0);
        last_o  = (cnt == len_i - CNT_W'(1));
    end

    // R2: the count never runs past the length of the phase it times.
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < len_i);
endmodule

// File: rtl/ddr2_init_cmd.sv
// Command decoder: turns the current phase into pins. A command is driven only on
// the first cycle of its phase; every other cycle is NOP.
// Assumes AP_BIT and DLL_RST_BIT lie inside the address width.
module ddr2_init_cmd
    import ddr2_init_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int BA_W        = 2,
    parameter int AP_BIT      = 10,
    parameter int DLL_RST_BIT = 8
) (
    input  phase_e            phase_i,
    input  logic              first_i,
    input  logic [ADDR_W-1:0] emr_val_i,
    input  logic [ADDR_W-1:0] mr_val_i,
    output logic              cke_o,
    output logic [2:0]        cmd_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] AP_MASK  = ADDR_W'(1) << AP_BIT;
    localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLL_RST_BIT;

    // Map phase and first-cycle flag to clock enable, command, bank and address.
    always_comb begin
        cke_o  = (phase_i != PH_PWR);
        done_o = (phase_i == PH_DONE);
        cmd_o  = CMD_NOP;
        ba_o   = '0;
        addr_o = '0;
        if (first_i) begin
            case (phase_i)
                PH_PALL1, PH_PALL2: begin
                    cmd_o  = CMD_PRE;
                    addr_o = AP_MASK;
                end
                PH_EMR: begin
                    cmd_o  = CMD_LMR;
                    ba_o   = BA_W'(1);
                    addr_o = emr_val_i;
                end
                PH_MRDLL: begin
                    cmd_o  = CMD_LMR;
                    addr_o = mr_val_i | DLL_MASK;
                end
                PH_REF1, PH_REF2: cmd_o = CMD_REF;
                PH_MRRUN: begin
                    cmd_o  = CMD_LMR;
                    addr_o = mr_val_i & ~DLL_MASK;
                end
                default: cmd_o = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ddr2_init_seq.sv
// DDR2 power-up initialization sequencer (top).
// Steps the phase register through the fixed power-up order. Each phase length
// is a parameter in clock cycles. All lengths must be at least 1.
// Assumes clk is the memory clock and reset is synchronous, active low.
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int BA_W        = 2,
    parameter int AP_BIT      = 10,
    parameter int DLL_RST_BIT = 8,
    parameter int PWR_WAIT    = 50000,
    parameter int CKE_GAP     = 100,
    parameter int TRP         = 3,
    parameter int TMRD        = 2,
    parameter int TRFC        = 28,
    parameter int DLL_WAIT    = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] emr_val_i,
    input  logic [ADDR_W-1:0] mr_val_i,
    output logic              cke_o,
    output logic [2:0]        cmd_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);
    localparam int MAX_LEN = max_of(max_of(max_of(PWR_WAIT, CKE_GAP), max_of(TRP, TMRD)),
                                    max_of(TRFC, DLL_WAIT));
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    phase_e           phase;
    logic [CNT_W-1:0] len;
    logic             first, last;

    // Select the length of the current phase.
    always_comb begin
        case (phase)
            PH_PWR:             len = CNT_W'(PWR_WAIT);
            PH_CKE:             len = CNT_W'(CKE_GAP);
            PH_PALL1, PH_PALL2: len = CNT_W'(TRP);
            PH_EMR:             len = CNT_W'(TMRD);
            PH_MRDLL, PH_MRRUN: len = CNT_W'(DLL_WAIT);
            PH_REF1, PH_REF2:   len = CNT_W'(TRFC);
            default:            len = CNT_W'(1);
        endcase
    end

    // Advance to the next phase when the current one ends; hold in PH_DONE.
    always_ff @(posedge clk) begin
        if (!rst_n)                          phase <= PH_PWR;
        else if (last && phase != PH_DONE)   phase <= phase_e'(phase + 4'd1);
    end

    ddr2_init_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .len_i   (len),
        .first_o (first),
        .last_o  (last)
    );

    ddr2_init_cmd #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT), .DLL_RST_BIT(DLL_RST_BIT)
    ) u_cmd (
        .phase_i   (phase),
        .first_i   (first),
        .emr_val_i (emr_val_i),
        .mr_val_i  (mr_val_i),
        .cke_o     (cke_o),
        .cmd_o     (cmd_o),
        .ba_o      (ba_o),
        .addr_o    (addr_o),
        .done_o    (done_o)
    );

    // R3: a command other than NOP only ever goes out with clock enable high.
    p_cmd_cke_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != CMD_NOP) |-> cke_o);
    // R2: once raised, clock enable stays high until reset.
    p_cke_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cke_o |=> cke_o);
    // R9: done is sticky until reset.
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);
    // R9: after completion the bus stays idle.
    p_done_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cmd_o == CMD_NOP && cke_o));
endmodule

// File: tb/ddr2_init_seq_bench.sv
`timescale 1ns/1ps
module ddr2_init_seq_bench;
    localparam int AW = 14, BW = 2;
    localparam int PW = 40, CG = 4, RP = 3, MRD = 2, RFC = 9, DW = 200;
    localparam int DONE_IDX = PW + CG + RP + MRD + DW + RP + RFC + RFC + DW;
    localparam logic [2:0] NOP = 3'b111, PRE = 3'b010, REF = 3'b001, LMR = 3'b000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] emr, mr;
    logic cke, done;
    logic [2:0] cmd;
    logic [BW-1:0] ba;
    logic [AW-1:0] addr;
    int checks = 0, errors = 0, samp = 0;

    always #2 clk = ~clk;

    ddr2_init_seq #(
        .ADDR_W(AW), .BA_W(BW), .AP_BIT(10), .DLL_RST_BIT(8), .PWR_WAIT(PW),
        .CKE_GAP(CG), .TRP(RP), .TMRD(MRD), .TRFC(RFC), .DLL_WAIT(DW)
    ) u_ddr2_init_seq (
        .clk(clk), .rst_n(rst_n), .emr_val_i(emr), .mr_val_i(mr),
        .cke_o(cke), .cmd_o(cmd), .ba_o(ba), .addr_o(addr), .done_o(done)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (sample %0d)", what, act, exp, samp);
        end
    endtask

    // Step n samples; intermediate samples must be NOP with the given clock enable.
    task automatic adv(input int n, input bit cke_mid, input string what);
        bit bad = 0;
        int badv = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            samp++;
            if (k < n - 1 && !bad && (cmd !== NOP || cke !== cke_mid || done !== 1'b0)) begin
                bad = 1;
                badv = {cmd, cke, done};
            end
        end
        chk(!bad, what, badv, {NOP, cke_mid, 1'b0});
    endtask

    task automatic chk_cmd(input logic [2:0] c, input logic [BW-1:0] b,
                           input logic [AW-1:0] a, input string what);
        chk(cmd === c && ba === b && addr === a && cke === 1'b1 && done === 1'b0, what,
            {cmd, ba, addr}, {c, b, a});
    endtask

    task automatic chk_idle(input string what);
        chk(cke === 1'b0 && cmd === NOP && done === 1'b0 && ba === '0 && addr === '0,
            what, {cke, cmd, done}, {1'b0, NOP, 1'b0});
    endtask

    task automatic release_rst;
        @(negedge clk);
        rst_n = 1'b1;
        samp = 0;
    endtask

    task automatic apply_rst;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_idle("R10 reset returns to power-wait state");
    endtask

    // Full sequence from the release sample; checks every spacing and value.
    task automatic run_seq;
        chk_idle("R1 first sample after release");
        adv(PW, 1'b0, "R1 clock enable low and NOP during power wait");
        chk(cke === 1'b1 && cmd === NOP, "R2 clock enable rises after PWR_WAIT", {cke, cmd}, {1'b1, NOP});
        adv(CG, 1'b1, "R9 NOP during settle gap");
        chk_cmd(PRE, '0, AW'(14'h0400), "R3 first precharge all");
        adv(RP, 1'b1, "R9 NOP after precharge");
        chk_cmd(LMR, BW'(1), emr, "R4 extended mode load");
        adv(MRD, 1'b1, "R9 NOP after extended load");
        chk_cmd(LMR, '0, mr | AW'(14'h0100), "R5 mode load with DLL reset");
        adv(DW, 1'b1, "R9 NOP during DLL settle");
        chk_cmd(PRE, '0, AW'(14'h0400), "R6 second precharge all");
        adv(RP, 1'b1, "R9 NOP after second precharge");
        chk_cmd(REF, '0, '0, "R7 first refresh");
        adv(RFC, 1'b1, "R9 NOP after first refresh");
        chk_cmd(REF, '0, '0, "R7 second refresh");
        adv(RFC, 1'b1, "R9 NOP after second refresh");
        chk_cmd(LMR, '0, mr & ~AW'(14'h0100), "R8 mode load releasing DLL reset");
        adv(DW, 1'b1, "R9 NOP during lock wait");
        chk(done === 1'b1 && cmd === NOP && cke === 1'b1, "R9 done rises after lock wait",
            {done, cmd, cke}, {1'b1, NOP, 1'b1});
        begin
            bit bad = 0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                samp++;
                if (done !== 1'b1 || cmd !== NOP || cke !== 1'b1) bad = 1;
            end
            chk(!bad, "R9 done sticky and bus idle afterwards", bad, 0);
        end
    endtask

    task automatic t_reset_state;
        emr = 14'h0408;
        mr  = 14'h0233;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        chk_idle("R1 outputs while reset held");
    endtask

    task automatic t_seq_typical;
        release_rst();
        run_seq();
    endtask

    task automatic t_seq_dll_bit_preset;
        apply_rst();
        emr = 14'h0004;
        mr  = 14'h0343;
        release_rst();
        run_seq();
    endtask

    task automatic t_reset_mid_sequence;
        apply_rst();
        emr = 14'h0408;
        mr  = 14'h0233;
        release_rst();
        repeat (PW + CG + RP + 1) begin
            @(negedge clk);
            samp++;
        end
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle("R10 reset mid-sequence returns to idle at once");
        release_rst();
        run_seq();
    endtask

    task automatic t_reset_at_done;
        apply_rst();
        release_rst();
        repeat (DONE_IDX - 1) begin
            @(negedge clk);
            samp++;
        end
        rst_n = 1'b0;
        @(negedge clk);
        samp++;
        chk(done === 1'b0 && cke === 1'b0, "R10 reset in done-rise cycle wins",
            {done, cke}, 0);
        release_rst();
        run_seq();
    endtask

    initial begin
        t_reset_state();
        t_seq_typical();
        t_seq_dll_bit_preset();
        t_reset_mid_sequence();
        t_reset_at_done();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule